// File: doc/BRIEF.md
# Channel Interrupt Aggregator

This block gathers interrupt causes from a multi-channel DMA engine and presents them on four independent interrupt outputs. Each channel can report two events, a descriptor-done pulse and an error pulse. For every output the block keeps its own copy of a per-channel status register and a per-channel mask register. Software can therefore serve one output from one processor and another output from a second processor without either one disturbing the other's view.

Channel direction is fixed by parity: even-numbered channels move data out (transmit) and odd-numbered channels move data in (receive). For each output the block forms a transmit summary word, a receive summary word and a global summary word. Bit k of the transmit word stands for channel 2k and bit k of the receive word stands for channel 2k+1. Transmit and receive start/stop command registers turn channels on and off by pair index. Events arriving on a channel that is switched off are dropped. Each interrupt output is a level that stays high while any bit of its three summary words is set.

Register access uses a single-cycle word port. A write commits on the clock edge. The read data is combinational from the address.

Top module: `chan_irq_aggregator`

## Requirements
- R1: After reset every status bit, mask bit, channel enable and global summary bit is zero, every summary word reads zero and `irq_o` is all low.
- R2: A `ev_done_i[c]` or `ev_err_i[c]` pulse on an enabled channel c sets, from the next clock edge, bit 0 (done) or bit 6 (error) of the status word of channel c in the bank of every output. The status word of channel c for output o is at address 0x400 + 8*c + o. A pulse on a disabled channel leaves its status unchanged.
- R3: Writing a status word clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask word of channel c for output o is at 0x404 + 8*c + o and uses the same bit positions as the status word. Bit k of the transmit summary of output o (address 0x010 + o) is the OR over bits 0 and 6 of that bank's status AND mask for channel 2k. Bit k of the receive summary (address 0x014 + o) is the same OR for channel 2k+1.
- R6: Writing bit k as 1 to 0x000 enables channel 2k, and writing it to 0x001 disables channel 2k. Writing bit k as 1 to 0x002 enables channel 2k+1, and writing it to 0x003 disables channel 2k+1. Zero bits have no effect. Reads of 0x000 and 0x002 return the transmit and receive enable vectors, one bit per pair.
- R7: A pulse on `glb_evt_i[o*GLB_W + j]` sets bit j of the global summary of output o, which reads at 0x018 + o. Writing exactly all ones to that address clears it, any other written value leaves it unchanged, and an event in the same cycle as the clear stays set.
- R8: `irq_o[o]` is high exactly when the transmit, receive or global summary of output o has any bit set. It follows a status change from the same clock edge.
- R9: A status clear or a mask write in one output's bank leaves the other outputs' banks unchanged.
- R10: Reads of unmapped addresses return zero. Accesses to channel numbers at or above `NUM_CHAN` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_done_i | input | NUM_CHAN | Per-channel descriptor-done event pulse |
| ev_err_i | input | NUM_CHAN | Per-channel error event pulse |
| glb_evt_i | input | NUM_OUT*GLB_W | Global event pulses, GLB_W bits per output |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | NUM_OUT | Level interrupt per output |

## Verification
All state is reachable through the register port, and the summaries and interrupt lines are combinational views of that state. A wrong status, mask or enable bit therefore shows up at the ports in the cycle right after the edge that stored it. It appears either in the channel's own readback word or as a wrong bit in a summary word and its `irq_o` line. Mistakes in bank replication, such as a clear leaking into another output, show up only when the same channel is read through a second output's address, so the checks read each affected channel through at least two banks. Priority mistakes between a set and a clear in the same cycle show up only by driving both in the same cycle, and this is checked for the status bits and for the global summary.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // status and mask bit positions inside a channel word
    localparam int DONE_BIT = 0;
    localparam int ERR_BIT  = 6;

    // channel command registers
    localparam logic [ADDR_W-1:0] A_TX_START = 12'h000;
    localparam logic [ADDR_W-1:0] A_TX_STOP  = 12'h001;
    localparam logic [ADDR_W-1:0] A_RX_START = 12'h002;
    localparam logic [ADDR_W-1:0] A_RX_STOP  = 12'h003;

    // per-output summary words, base + output index
    localparam logic [ADDR_W-1:0] A_TX_SUM   = 12'h010;
    localparam logic [ADDR_W-1:0] A_RX_SUM   = 12'h014;
    localparam logic [ADDR_W-1:0] A_GLB_SUM  = 12'h018;

    // channel region: addr[11:10] == 2'b01, channel in addr[9:3],
    // addr[2] selects mask, addr[1:0] selects output bank
    localparam logic [1:0] CH_REGION = 2'b01;
    localparam int CH_LSB  = 3;
    localparam int CH_MSB  = 9;
    localparam int SEL_BIT = 2;

endpackage

// File: rtl/irq_aggr_chan_en.sv
module irq_aggr_chan_en
    import irq_aggr_pkg::*;
#(
    parameter int NUM_CHAN = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [NUM_CHAN-1:0]        en_o,
    output logic [NUM_CHAN/2-1:0]      tx_en_o,
    output logic [NUM_CHAN/2-1:0]      rx_en_o
);

    localparam int NUM_PAIR = NUM_CHAN / 2;

    typedef struct packed {
        logic [NUM_PAIR-1:0] tx;
        logic [NUM_PAIR-1:0] rx;
    } en_state_t;

    en_state_t st_d, st_q;
    logic [NUM_PAIR-1:0] wr_bits;

    assign wr_bits = wdata_i[NUM_PAIR-1:0];

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            case (addr_i)
                A_TX_START: st_d.tx = st_q.tx | wr_bits;
                A_TX_STOP:  st_d.tx = st_q.tx & ~wr_bits;
                A_RX_START: st_d.rx = st_q.rx | wr_bits;
                A_RX_STOP:  st_d.rx = st_q.rx & ~wr_bits;
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // even channels take the transmit bits, odd channels the receive bits
    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
        assign en_o[2*k]   = st_q.tx[k];
        assign en_o[2*k+1] = st_q.rx[k];
    end

    assign tx_en_o = st_q.tx;
    assign rx_en_o = st_q.rx;

    // R6: a start write turns on every pair it names
    a_r6_tx_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_TX_START) |=> ((st_q.tx & $past(wr_bits)) == $past(wr_bits)));

    // R6: a stop write turns off every pair it names
    a_r6_rx_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == A_RX_STOP) |=> ((st_q.rx & $past(wr_bits)) == '0));

    // R6: enables only move on a write
    a_r6_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(st_q));

endmodule

// File: rtl/irq_aggr_bank.sv
module irq_aggr_bank
    import irq_aggr_pkg::*;
#(
    parameter int NUM_CHAN = 16,
    parameter int GLB_W    = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_CHAN-1:0]   ev_done_i,
    input  logic [NUM_CHAN-1:0]   ev_err_i,
    input  logic [NUM_CHAN-1:0]   en_i,
    input  logic [NUM_CHAN-1:0]   stat_we_i,
    input  logic [NUM_CHAN-1:0]   mask_we_i,
    input  logic                  wr_done_i,
    input  logic                  wr_err_i,
    input  logic [GLB_W-1:0]      glb_evt_i,
    input  logic                  glb_clr_i,
    output logic [NUM_CHAN-1:0]   done_o,
    output logic [NUM_CHAN-1:0]   err_o,
    output logic [NUM_CHAN-1:0]   mdone_o,
    output logic [NUM_CHAN-1:0]   merr_o,
    output logic [NUM_CHAN/2-1:0] tx_sum_o,
    output logic [NUM_CHAN/2-1:0] rx_sum_o,
    output logic [GLB_W-1:0]      glb_o,
    output logic                  irq_o
);

    localparam int NUM_PAIR = NUM_CHAN / 2;

    typedef struct packed {
        logic [NUM_CHAN-1:0] done;
        logic [NUM_CHAN-1:0] err;
        logic [NUM_CHAN-1:0] mdone;
        logic [NUM_CHAN-1:0] merr;
        logic [GLB_W-1:0]    glb;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [NUM_CHAN-1:0] set_done, set_err;
    logic [NUM_CHAN-1:0] clr_done, clr_err;
    logic [NUM_CHAN-1:0] pend;

    always_comb begin
        set_done = ev_done_i & en_i;
        set_err  = ev_err_i & en_i;
        clr_done = stat_we_i & {NUM_CHAN{wr_done_i}};
        clr_err  = stat_we_i & {NUM_CHAN{wr_err_i}};

        st_d = st_q;
        // the set term is ORed after the clear, so a same-cycle event wins
        st_d.done  = (st_q.done & ~clr_done) | set_done;
        st_d.err   = (st_q.err  & ~clr_err)  | set_err;
        st_d.mdone = (st_q.mdone & ~mask_we_i) | (mask_we_i & {NUM_CHAN{wr_done_i}});
        st_d.merr  = (st_q.merr  & ~mask_we_i) | (mask_we_i & {NUM_CHAN{wr_err_i}});
        st_d.glb   = (glb_clr_i ? '0 : st_q.glb) | glb_evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = (st_q.done & st_q.mdone) | (st_q.err & st_q.merr);

    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_sum
        assign tx_sum_o[k] = pend[2*k];
        assign rx_sum_o[k] = pend[2*k+1];
    end

    assign done_o  = st_q.done;
    assign err_o   = st_q.err;
    assign mdone_o = st_q.mdone;
    assign merr_o  = st_q.merr;
    assign glb_o   = st_q.glb;
    assign irq_o   = (|tx_sum_o) | (|rx_sum_o) | (|st_q.glb);

    // R2: an enabled done event is recorded on the next edge
    a_r2_done_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.done & $past(ev_done_i & en_i)) == $past(ev_done_i & en_i)));

    // R2: an enabled error event is recorded on the next edge
    a_r2_err_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.err & $past(ev_err_i & en_i)) == $past(ev_err_i & en_i)));

    // R2: no status bit rises without an enabled event
    a_r2_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.done & ~$past(st_q.done) & ~$past(ev_done_i & en_i)) == '0));

    // R3: a cleared done bit with no competing event is gone
    a_r3_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((st_q.done & $past(stat_we_i & {NUM_CHAN{wr_done_i}} & ~(ev_done_i & en_i))) == '0));

    // R5: with every mask bit off no channel summary can be raised
    a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mdone == '0 && st_q.merr == '0) |-> (tx_sum_o == '0 && rx_sum_o == '0));

    // R7: an all-ones write with no event empties the global word
    a_r7_glb_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (glb_clr_i && glb_evt_i == '0) |=> (glb_o == '0));

endmodule

// File: rtl/chan_irq_aggregator.sv
module chan_irq_aggregator
    import irq_aggr_pkg::*;
#(
    parameter int NUM_CHAN = 16,
    parameter int NUM_OUT  = 4,
    parameter int GLB_W    = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_CHAN-1:0]      ev_done_i,
    input  logic [NUM_CHAN-1:0]      ev_err_i,
    input  logic [NUM_OUT*GLB_W-1:0] glb_evt_i,
    input  logic                     reg_we_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [DATA_W-1:0]        reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    output logic [NUM_OUT-1:0]       irq_o
);

    localparam int NUM_PAIR = NUM_CHAN / 2;
    localparam int CH_W     = CH_MSB - CH_LSB + 1;

    logic [NUM_CHAN-1:0] ch_en;
    logic [NUM_PAIR-1:0] tx_en, rx_en;
    logic                ch_region;
    logic [NUM_CHAN-1:0] ch_hit;

    logic [NUM_CHAN-1:0] b_done  [NUM_OUT];
    logic [NUM_CHAN-1:0] b_err   [NUM_OUT];
    logic [NUM_CHAN-1:0] b_mdone [NUM_OUT];
    logic [NUM_CHAN-1:0] b_merr  [NUM_OUT];
    logic [NUM_PAIR-1:0] b_tx    [NUM_OUT];
    logic [NUM_PAIR-1:0] b_rx    [NUM_OUT];
    logic [GLB_W-1:0]    b_glb   [NUM_OUT];

    irq_aggr_chan_en #(
        .NUM_CHAN (NUM_CHAN)
    ) i_chan_en (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .en_o    (ch_en),
        .tx_en_o (tx_en),
        .rx_en_o (rx_en)
    );

    assign ch_region = (reg_addr_i[ADDR_W-1:CH_MSB+1] == CH_REGION);

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_hit
        assign ch_hit[c] = ch_region && (reg_addr_i[CH_MSB:CH_LSB] == CH_W'(c));
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        localparam logic [ADDR_W-1:0] GLB_ADDR = ADDR_W'(A_GLB_SUM + o);

        logic                bank_sel;
        logic [NUM_CHAN-1:0] stat_we, mask_we;
        logic                glb_clr;

        assign bank_sel = reg_we_i && (reg_addr_i[1:0] == 2'(o));
        assign stat_we  = {NUM_CHAN{bank_sel && !reg_addr_i[SEL_BIT]}} & ch_hit;
        assign mask_we  = {NUM_CHAN{bank_sel &&  reg_addr_i[SEL_BIT]}} & ch_hit;
        assign glb_clr  = reg_we_i && (reg_addr_i == GLB_ADDR) && (&reg_wdata_i);

        irq_aggr_bank #(
            .NUM_CHAN (NUM_CHAN),
            .GLB_W    (GLB_W)
        ) i_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ev_done_i (ev_done_i),
            .ev_err_i  (ev_err_i),
            .en_i      (ch_en),
            .stat_we_i (stat_we),
            .mask_we_i (mask_we),
            .wr_done_i (reg_wdata_i[DONE_BIT]),
            .wr_err_i  (reg_wdata_i[ERR_BIT]),
            .glb_evt_i (glb_evt_i[o*GLB_W +: GLB_W]),
            .glb_clr_i (glb_clr),
            .done_o    (b_done[o]),
            .err_o     (b_err[o]),
            .mdone_o   (b_mdone[o]),
            .merr_o    (b_merr[o]),
            .tx_sum_o  (b_tx[o]),
            .rx_sum_o  (b_rx[o]),
            .glb_o     (b_glb[o]),
            .irq_o     (irq_o[o])
        );
    end

    // read-back multiplexer
    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == A_TX_START) reg_rdata_o[NUM_PAIR-1:0] = tx_en;
        if (reg_addr_i == A_RX_START) reg_rdata_o[NUM_PAIR-1:0] = rx_en;
        for (int o = 0; o < NUM_OUT; o++) begin
            if (reg_addr_i == ADDR_W'(A_TX_SUM + o))  reg_rdata_o[NUM_PAIR-1:0] = b_tx[o];
            if (reg_addr_i == ADDR_W'(A_RX_SUM + o))  reg_rdata_o[NUM_PAIR-1:0] = b_rx[o];
            if (reg_addr_i == ADDR_W'(A_GLB_SUM + o)) reg_rdata_o[GLB_W-1:0]    = b_glb[o];
            for (int c = 0; c < NUM_CHAN; c++) begin
                if (ch_hit[c] && reg_addr_i[1:0] == 2'(o)) begin
                    if (reg_addr_i[SEL_BIT]) begin
                        reg_rdata_o[DONE_BIT] = b_mdone[o][c];
                        reg_rdata_o[ERR_BIT]  = b_merr[o][c];
                    end else begin
                        reg_rdata_o[DONE_BIT] = b_done[o][c];
                        reg_rdata_o[ERR_BIT]  = b_err[o][c];
                    end
                end
            end
        end
    end

    // R8: a raised line always has a summary word behind it
    a_r8_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[0] |-> ((|b_tx[0]) || (|b_rx[0]) || (|b_glb[0])));

endmodule

// File: tb/test_chan_irq_aggregator.sv
module test_chan_irq_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 16;
    localparam int NOUT = 4;
    localparam int GW   = 4;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_EV = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;
        logic [31:0] data;   // OP_EV: [15:0] done pulses, [31:16] error pulses
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    localparam int NSTEP = 31;
    localparam step_t TBL [NSTEP] = '{
        '{OP_WR, 12'h000, 32'h5,        32'h0,  4'd6},   // R6 enable ch0, ch4
        '{OP_RD, 12'h000, 32'h0,        32'h5,  4'd6},   // R6
        '{OP_WR, 12'h002, 32'h2,        32'h0,  4'd6},   // R6 enable ch3
        '{OP_RD, 12'h002, 32'h0,        32'h2,  4'd6},   // R6
        '{OP_EV, 12'h000, 32'h1,        32'h0,  4'd2},   // R2 done ch0
        '{OP_RD, 12'h400, 32'h0,        32'h1,  4'd2},   // R2 bank 0
        '{OP_RD, 12'h402, 32'h0,        32'h1,  4'd2},   // R2 bank 2
        '{OP_EV, 12'h000, 32'h0008_0000,32'h0,  4'd2},   // R2 err ch3
        '{OP_RD, 12'h419, 32'h0,        32'h40, 4'd2},   // R2 ch3 bank 1
        '{OP_EV, 12'h000, 32'h2,        32'h0,  4'd2},   // R2 ch1 disabled
        '{OP_RD, 12'h408, 32'h0,        32'h0,  4'd2},   // R2
        '{OP_RD, 12'h010, 32'h0,        32'h0,  4'd5},   // R5 masked
        '{OP_WR, 12'h404, 32'h1,        32'h0,  4'd5},   // R5 unmask done ch0 bank 0
        '{OP_RD, 12'h010, 32'h0,        32'h1,  4'd5},   // R5
        '{OP_WR, 12'h41C, 32'h40,       32'h0,  4'd5},   // R5 unmask err ch3 bank 0
        '{OP_RD, 12'h014, 32'h0,        32'h2,  4'd5},   // R5
        '{OP_RD, 12'h011, 32'h0,        32'h0,  4'd9},   // R9 bank 1 unaffected
        '{OP_WR, 12'h400, 32'h40,       32'h0,  4'd3},   // R3 clear err only
        '{OP_RD, 12'h400, 32'h0,        32'h1,  4'd3},   // R3
        '{OP_WR, 12'h400, 32'h1,        32'h0,  4'd3},   // R3 clear done
        '{OP_RD, 12'h400, 32'h0,        32'h0,  4'd3},   // R3
        '{OP_RD, 12'h402, 32'h0,        32'h1,  4'd9},   // R9 bank 2 kept
        '{OP_RD, 12'h010, 32'h0,        32'h0,  4'd5},   // R5
        '{OP_WR, 12'h001, 32'h1,        32'h0,  4'd6},   // R6 stop ch0
        '{OP_RD, 12'h000, 32'h0,        32'h4,  4'd6},   // R6
        '{OP_EV, 12'h000, 32'h1,        32'h0,  4'd6},   // R6 event on stopped ch0
        '{OP_RD, 12'h400, 32'h0,        32'h0,  4'd6},   // R6
        '{OP_WR, 12'h484, 32'h41,       32'h0,  4'd10},  // R10 channel 16 absent
        '{OP_RD, 12'h480, 32'h0,        32'h0,  4'd10},  // R10
        '{OP_RD, 12'h3F0, 32'h0,        32'h0,  4'd10},  // R10 unmapped
        '{OP_RD, 12'h404, 32'h0,        32'h1,  4'd5}    // R5 mask read-back
    };

    logic                 clk_i = 1'b0;
    logic                 rst_ni = 1'b0;
    logic [NCH-1:0]       ev_done_i = '0;
    logic [NCH-1:0]       ev_err_i = '0;
    logic [NOUT*GW-1:0]   glb_evt_i = '0;
    logic                 reg_we_i = 1'b0;
    logic [11:0]          reg_addr_i = '0;
    logic [31:0]          reg_wdata_i = '0;
    logic [31:0]          reg_rdata_o;
    logic [NOUT-1:0]      irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    chan_irq_aggregator #(
        .NUM_CHAN (NCH),
        .NUM_OUT  (NOUT),
        .GLB_W    (GW)
    ) i_chan_irq_aggregator (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ev_done_i   (ev_done_i),
        .ev_err_i    (ev_err_i),
        .glb_evt_i   (glb_evt_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at the falling edge
    task automatic drive(input logic we, input logic [11:0] addr, input logic [31:0] data,
                         input logic [NCH-1:0] evd, input logic [NCH-1:0] eve,
                         input logic [NOUT*GW-1:0] glb);
        @(negedge clk_i);
        reg_we_i    = we;
        reg_addr_i  = addr;
        reg_wdata_i = data;
        ev_done_i   = evd;
        ev_err_i    = eve;
        glb_evt_i   = glb;
    endtask

    task automatic rd_chk(input logic [11:0] addr, input logic [31:0] exp, input string req);
        drive(1'b0, addr, 32'h0, '0, '0, '0);
        #1;
        chk(req, reg_rdata_o, exp);
    endtask

    task automatic irq_chk(input logic [NOUT-1:0] exp, input string req);
        drive(1'b0, 12'h3F0, 32'h0, '0, '0, '0);
        #1;
        chk(req, 32'(irq_o), 32'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL R1: watchdog expired, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1;
        chk("R1 irq during reset", 32'(irq_o), 32'h0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R1: reset state
        irq_chk('0, "R1 irq after reset");
        rd_chk(12'h000, 32'h0, "R1 tx enables");
        rd_chk(12'h002, 32'h0, "R1 rx enables");
        rd_chk(12'h400, 32'h0, "R1 status");
        rd_chk(12'h404, 32'h0, "R1 mask");
        rd_chk(12'h013, 32'h0, "R1 tx summary");
        rd_chk(12'h01B, 32'h0, "R1 global");

        // table walk
        for (int i = 0; i < NSTEP; i++) begin
            case (TBL[i].op)
                OP_WR: drive(1'b1, TBL[i].addr, TBL[i].data, '0, '0, '0);
                OP_EV: drive(1'b0, 12'h3F0, 32'h0, TBL[i].data[15:0], TBL[i].data[31:16], '0);
                default: rd_chk(TBL[i].addr, TBL[i].exp,
                                $sformatf("R%0d step %0d", TBL[i].req, i));
            endcase
        end

        // R8: ch3 error unmasked in bank 0 only
        irq_chk(4'b0001, "R8 rx summary drives irq0");

        // R4: event and clear on ch4 done, bank 0, same cycle
        drive(1'b0, 12'h3F0, 32'h0, 16'h0010, '0, '0);
        rd_chk(12'h420, 32'h1, "R2 ch4 done");
        drive(1'b1, 12'h420, 32'h1, 16'h0010, '0, '0);
        rd_chk(12'h420, 32'h1, "R4 event beats clear");
        drive(1'b1, 12'h420, 32'h1, '0, '0, '0);
        rd_chk(12'h420, 32'h0, "R3 clear ch4");
        rd_chk(12'h421, 32'h1, "R9 ch4 bank 1 kept");

        // R7: global summary of output 2
        drive(1'b0, 12'h3F0, 32'h0, '0, '0, 16'h0500);
        rd_chk(12'h01A, 32'h5, "R7 global set");
        irq_chk(4'b0101, "R8 global drives irq2");
        drive(1'b1, 12'h01A, 32'h1, '0, '0, '0);
        rd_chk(12'h01A, 32'h5, "R7 partial write ignored");
        drive(1'b1, 12'h01A, 32'hFFFF_FFFF, '0, '0, '0);
        rd_chk(12'h01A, 32'h0, "R7 all-ones clear");
        drive(1'b1, 12'h01A, 32'hFFFF_FFFF, '0, '0, 16'h0200);
        rd_chk(12'h01A, 32'h2, "R7 event beats clear");
        drive(1'b1, 12'h01A, 32'hFFFF_FFFF, '0, '0, '0);
        irq_chk(4'b0001, "R8 irq2 drops");

        // R8: clearing ch3 error in bank 0 drops irq0
        drive(1'b1, 12'h418, 32'h40, '0, '0, '0);
        irq_chk(4'b0000, "R8 irq0 drops");
        rd_chk(12'h419, 32'h40, "R9 ch3 bank 1 kept");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule